// File: doc/BRIEF.md
# Banked Masked-Write Control Register File

This block holds the system-control registers of a small multithreaded core. Software reaches a register through a 5-bit register number and a 3-bit select. The flat slot index is `num*8 + sel`, so every register number owns eight select slots. Each implemented register has a constant write mask. A software write changes only the bits the mask allows, and the other bits keep their value. A raw back-door write, used by the core's own hardware and by test access, stores the whole word and ignores the mask.

Every register is stored in one of three ways:
- one copy shared by the whole core;
- one copy per virtual processor;
- one copy per hardware thread.

A per-thread register is selected directly by the requesting thread id. A per-virtual-processor register is selected by the virtual-processor field of that thread's binding register, so rewriting a binding moves the thread to another bank. Reads are combinational, and writes land on the next rising clock edge.

Slot map (num,sel):

| Bank | Slots |
|------|-------|
| Shared | (0,0) (1,0) (2,0) (3,0) (4,0) (5,0) (5,1) (8,0) (12,1) (12,2) (13,0) (15,0) (16,0) (16,1) (16,3) |
| Per virtual processor | (1,1) (1,2) (6,1) (15,1) |
| Per thread | (2,1) (2,2) (2,4) (12,0) (17,0) (23,0) |

Every other slot is unimplemented.

Top module: `crf_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, every register takes its reset value, and all values not listed here are 0:
  - (1,0) takes 63.
  - (15,0) takes parameter `CORE_ID_RESET`.
  - (16,0) takes 0x80000000.
  - Every bank of (15,1) takes 0x80000000.
  - Each thread's (12,0) takes 0x00400004.
  - Each thread's binding register (2,2) takes its own thread id in bits [28:21].
- R2: A software write (`wr_en`=1, `wr_raw`=0) stores `(wr_data & M) | (old & ~M)`. M is:
  - 0x7FFFFFFF for (0,0), and 0x3FFFFFFF for (2,0) and (3,0);
  - 0xFF800000 for (4,0), 0x1FFFF800 for (5,0) and 0x10000000 for (5,1);
  - 0x000003E0 for (12,1), 0x0000F3C0 for (12,2) and 0x08C00300 for (13,0);
  - 0x3FFFF000 for (15,1), 0x7FFF0007 for (16,0) and 0xFF78FF17 for (12,0);
  - all ones for (1,1), (1,2), (6,1), (2,1), (2,2), (2,4) and (23,0).
- R3: Slots (1,0), (8,0), (15,0), (16,1), (16,3) and (17,0) have a zero mask, so a software write leaves them unchanged.
- R4: A raw write (`wr_en`=1, `wr_raw`=1) to an implemented slot stores `wr_data` unmasked.
- R5: A per-thread register read or written with thread id t accesses only thread t's copy.
- R6: A per-virtual-processor register accessed by thread t uses the bank numbered by bits [3:0] of thread t's binding register (2,2). Changing those bits reroutes later accesses.
- R7: A shared register holds one value, whichever thread id writes or reads it.
- R8: An unimplemented slot reads 0, and writes to it change no register.
- R9: If the virtual-processor field of the thread's binding is not below `NUM_VP`, per-virtual-processor accesses read 0 and writes are dropped.
- R10: `rd_data` follows the addressed register combinationally. A write becomes visible only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tid | input | TID_W | Requesting thread id |
| reg_num | input | 5 | Register number |
| reg_sel | input | 3 | Select within the register number |
| wr_en | input | 1 | Write strobe |
| wr_raw | input | 1 | With `wr_en`, write bypasses the mask |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed slot and bank |

## Verification
The bench goes after the following corner cases:
- **Masked merge with a neighbour's mask.** A design that applies the wrong mask to a slot, or keeps the old bits inverted, shows wrong bits after all-ones and all-zeros writes to each shared register.
- **Thread-bank decode.** A design that indexes the virtual-processor bank by thread id instead of by the binding field shows the same EBase for both bound threads, or a changed value after rebinding.
- **Out-of-range binding.** A design that wraps an out-of-range binding into bank 0 corrupts thread 0's view.
- **Aliased unimplemented slots.** A design that aliases unimplemented slots onto a neighbour returns data where zero is expected.
- **Write timing.** A write that became visible in the same cycle would be caught by the comparison made before the edge.

// File: rtl/crf_pkg.sv
// Shared types and constant tables of the banked control register file.
// Assumes a 32-bit word, a 5-bit register number and a 3-bit select.
package crf_pkg;

    localparam int DATA_W = 32;
    localparam int ORD_W  = 4;   // ordinal of a register inside its bank
    localparam int CPY_W  = 4;   // copy (bank) number width
    localparam int IDX_W  = 8;   // flat slot index num*8+sel

    localparam int N_CORE = 15;
    localparam int N_VPR  = 4;
    localparam int N_THR  = 6;

    // Binding register ordinal in the per-thread bank and its field layout
    localparam logic [ORD_W-1:0] THR_BIND_ORD = 4'd1;
    localparam int CURTC_LSB = 21;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_CORE = 2'd1,
        K_VPR  = 2'd2,
        K_THR  = 2'd3
    } bank_e;

    typedef struct packed {
        bank_e             kind;
        logic [ORD_W-1:0]  ord;
    } slot_t;

    // Map a flat slot index to its bank kind and ordinal.
    function automatic slot_t slot_of(input logic [IDX_W-1:0] idx);
        slot_t r;
        r = '{kind: K_NONE, ord: '0};
        case (idx)
            8'd0:   r = '{K_CORE, 4'd0};   // index
            8'd8:   r = '{K_CORE, 4'd1};   // random
            8'd16:  r = '{K_CORE, 4'd2};   // entry low 0
            8'd24:  r = '{K_CORE, 4'd3};   // entry low 1
            8'd32:  r = '{K_CORE, 4'd4};   // context
            8'd40:  r = '{K_CORE, 4'd5};   // page mask
            8'd41:  r = '{K_CORE, 4'd6};   // page grain
            8'd64:  r = '{K_CORE, 4'd7};   // bad address
            8'd97:  r = '{K_CORE, 4'd8};   // interrupt control
            8'd98:  r = '{K_CORE, 4'd9};   // shadow set control
            8'd104: r = '{K_CORE, 4'd10};  // cause
            8'd120: r = '{K_CORE, 4'd11};  // processor id
            8'd128: r = '{K_CORE, 4'd12};  // config
            8'd129: r = '{K_CORE, 4'd13};  // config 1
            8'd131: r = '{K_CORE, 4'd14};  // config 3
            8'd9:   r = '{K_VPR,  4'd0};   // vp control
            8'd10:  r = '{K_VPR,  4'd1};   // vp config
            8'd49:  r = '{K_VPR,  4'd2};   // shadow set config
            8'd121: r = '{K_VPR,  4'd3};   // exception base
            8'd17:  r = '{K_THR,  4'd0};   // thread status
            8'd18:  r = '{K_THR,  4'd1};   // thread binding
            8'd20:  r = '{K_THR,  4'd2};   // thread halt
            8'd96:  r = '{K_THR,  4'd3};   // status
            8'd136: r = '{K_THR,  4'd4};   // linked address
            8'd184: r = '{K_THR,  4'd5};   // debug
            default: r = '{K_NONE, 4'd0};
        endcase
        return r;
    endfunction

    // Constant write mask of a register.
    function automatic logic [DATA_W-1:0] wmask(input bank_e k, input int ord);
        logic [DATA_W-1:0] m;
        m = '1;
        if (k == K_CORE) begin
            case (ord)
                0:       m = 32'h7FFF_FFFF;
                2, 3:    m = 32'h3FFF_FFFF;
                4:       m = 32'hFF80_0000;
                5:       m = 32'h1FFF_F800;
                6:       m = 32'h1000_0000;
                8:       m = 32'h0000_03E0;
                9:       m = 32'h0000_F3C0;
                10:      m = 32'h08C0_0300;
                12:      m = 32'h7FFF_0007;
                default: m = '0;   // 1, 7, 11, 13, 14 are read-only
            endcase
        end else if (k == K_VPR) begin
            m = (ord == 3) ? 32'h3FFF_F000 : '1;
        end else if (k == K_THR) begin
            case (ord)
                3:       m = 32'hFF78_FF17;
                4:       m = '0;
                default: m = '1;
            endcase
        end
        return m;
    endfunction

    // Reset value of copy cpy of a register.
    function automatic logic [DATA_W-1:0] rstval(input bank_e k, input int ord,
                                                 input int cpy,
                                                 input logic [DATA_W-1:0] core_id);
        logic [DATA_W-1:0] v;
        v = '0;
        if (k == K_CORE) begin
            case (ord)
                1:       v = 32'd63;
                11:      v = core_id;
                12:      v = 32'h8000_0000;
                default: v = '0;
            endcase
        end else if (k == K_VPR) begin
            v = (ord == 3) ? 32'h8000_0000 : '0;
        end else if (k == K_THR) begin
            case (ord)
                1:       v = DATA_W'(cpy) << CURTC_LSB;
                3:       v = 32'h0040_0004;
                default: v = '0;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/crf_bank.sv
// One storage bank: COPIES copies of WORDS registers of kind KIND.
// Each register has a constant write mask and reset value taken from the
// package tables. A copy or ordinal that does not exist selects nothing:
// it reads zero, reports no hit and ignores writes.
module crf_bank
    import crf_pkg::*;
#(
    parameter bank_e                KIND          = K_CORE,
    parameter int                   COPIES        = 1,
    parameter int                   WORDS         = 1,
    parameter logic [DATA_W-1:0]    CORE_ID_RESET = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                raw,
    input  logic [CPY_W-1:0]    sel_copy,
    input  logic [ORD_W-1:0]    sel_ord,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic                hit
);

    localparam int NWORDS = COPIES * WORDS;

    logic [NWORDS-1:0][DATA_W-1:0] flat;

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        for (genvar o = 0; o < WORDS; o++) begin : g_word
            localparam logic [DATA_W-1:0] MASK = wmask(KIND, o);
            localparam logic [DATA_W-1:0] RSTV = rstval(KIND, o, c, CORE_ID_RESET);
            logic [DATA_W-1:0] q;
            logic              sel;

            // Address match for this one register copy
            assign sel = (sel_copy == CPY_W'(c)) && (sel_ord == ORD_W'(o));

            // Register update: reset load, raw store or masked merge
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= RSTV;
                end else if (we && sel) begin
                    q <= raw ? wdata : ((wdata & MASK) | (q & ~MASK));
                end
            end

            assign flat[c*WORDS + o] = q;
        end
    end

    // Read mux: OR of the single matching word, zero when none matches
    always_comb begin
        rdata = '0;
        hit   = 1'b0;
        for (int c = 0; c < COPIES; c++) begin
            for (int o = 0; o < WORDS; o++) begin
                if ((sel_copy == CPY_W'(c)) && (sel_ord == ORD_W'(o))) begin
                    rdata = rdata | flat[c*WORDS + o];
                    hit   = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/crf_route.sv
// Address routing: decodes num/sel into bank kind and ordinal, picks the copy
// in each bank, and steers the write strobe. The per-thread bank is read
// with the binding ordinal when a per-virtual-processor register is
// addressed, so that the binding's bank field can choose the copy.
module crf_route
    import crf_pkg::*;
#(
    parameter int TID_W = 2
) (
    input  logic [4:0]          reg_num,
    input  logic [2:0]          reg_sel,
    input  logic [TID_W-1:0]    tid,
    input  logic                wr_en,
    input  logic                thr_hit,
    input  logic [CPY_W-1:0]    bind_vp,
    output bank_e               kind,
    output logic [ORD_W-1:0]    ord,
    output logic [ORD_W-1:0]    thr_ord,
    output logic [CPY_W-1:0]    thr_copy,
    output logic [CPY_W-1:0]    vpr_copy,
    output logic                core_we,
    output logic                vpr_we,
    output logic                thr_we
);

    slot_t slot;

    // Slot decode from the flat index num*8+sel
    always_comb begin
        slot = slot_of({reg_num, reg_sel});
        kind = slot.kind;
        ord  = slot.ord;
    end

    // Copy selection and write steering per bank
    always_comb begin
        thr_copy = CPY_W'(tid);
        thr_ord  = (kind == K_VPR) ? THR_BIND_ORD : ord;
        vpr_copy = bind_vp;
        core_we  = wr_en && (kind == K_CORE);
        vpr_we   = wr_en && (kind == K_VPR) && thr_hit;
        thr_we   = wr_en && (kind == K_THR);
    end

endmodule

// File: rtl/crf_top.sv
// Banked masked-write control register file, top level.
// Assumes NUM_TC <= 16 and NUM_VP <= 16; reads are combinational, writes
// take effect on the next rising edge; reset is synchronous, active low.
module crf_top
    import crf_pkg::*;
#(
    parameter int                NUM_TC        = 4,
    parameter int                NUM_VP        = 2,
    parameter logic [31:0]       CORE_ID_RESET = 32'h0001_9300,
    localparam int               TID_W         = (NUM_TC > 1) ? $clog2(NUM_TC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TID_W-1:0]    tid,
    input  logic [4:0]          reg_num,
    input  logic [2:0]          reg_sel,
    input  logic                wr_en,
    input  logic                wr_raw,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data
);

    bank_e              kind;
    logic [ORD_W-1:0]   ord;
    logic [ORD_W-1:0]   thr_ord;
    logic [CPY_W-1:0]   thr_copy;
    logic [CPY_W-1:0]   vpr_copy;
    logic               core_we, vpr_we, thr_we;
    logic [DATA_W-1:0]  core_rd, vpr_rd, thr_rd;
    logic               core_hit, vpr_hit, thr_hit;

    crf_route #(.TID_W(TID_W)) u_route (
        .reg_num  (reg_num),
        .reg_sel  (reg_sel),
        .tid      (tid),
        .wr_en    (wr_en),
        .thr_hit  (thr_hit),
        .bind_vp  (thr_rd[CPY_W-1:0]),
        .kind     (kind),
        .ord      (ord),
        .thr_ord  (thr_ord),
        .thr_copy (thr_copy),
        .vpr_copy (vpr_copy),
        .core_we  (core_we),
        .vpr_we   (vpr_we),
        .thr_we   (thr_we)
    );

    crf_bank #(.KIND(K_CORE), .COPIES(1), .WORDS(N_CORE),
               .CORE_ID_RESET(CORE_ID_RESET)) u_core (
        .clk (clk), .rst_n (rst_n), .we (core_we), .raw (wr_raw),
        .sel_copy ('0), .sel_ord (ord), .wdata (wr_data),
        .rdata (core_rd), .hit (core_hit)
    );

    crf_bank #(.KIND(K_VPR), .COPIES(NUM_VP), .WORDS(N_VPR),
               .CORE_ID_RESET(CORE_ID_RESET)) u_vpr (
        .clk (clk), .rst_n (rst_n), .we (vpr_we), .raw (wr_raw),
        .sel_copy (vpr_copy), .sel_ord (ord), .wdata (wr_data),
        .rdata (vpr_rd), .hit (vpr_hit)
    );

    crf_bank #(.KIND(K_THR), .COPIES(NUM_TC), .WORDS(N_THR),
               .CORE_ID_RESET(CORE_ID_RESET)) u_thr (
        .clk (clk), .rst_n (rst_n), .we (thr_we), .raw (wr_raw),
        .sel_copy (thr_copy), .sel_ord (thr_ord), .wdata (wr_data),
        .rdata (thr_rd), .hit (thr_hit)
    );

    // Final read select by bank kind; a missing copy reads zero
    always_comb begin
        unique case (kind)
            K_CORE:  rd_data = core_hit ? core_rd : '0;
            K_VPR:   rd_data = (thr_hit && vpr_hit) ? vpr_rd : '0;
            K_THR:   rd_data = thr_hit ? thr_rd : '0;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/crf_top_checker.sv
// Temporal checks on the ports of crf_top, attached by bind.
// Assumes the reset values and masks listed in the requirements.
module crf_top_checker #(
    parameter int          TID_W         = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TID_W-1:0]    tid,
    input  logic [4:0]          reg_num,
    input  logic [2:0]          reg_sel,
    input  logic                wr_en,
    input  logic                wr_raw,
    input  logic [31:0]         wr_data,
    input  logic [31:0]         rd_data
);

    localparam logic [31:0] CAUSE_M = 32'h08C0_0300;

    logic at_cause, at_id, at_rand, at_bind;
    assign at_cause = (reg_num == 5'd13) && (reg_sel == 3'd0);
    assign at_id    = (reg_num == 5'd15) && (reg_sel == 3'd0);
    assign at_rand  = (reg_num == 5'd1)  && (reg_sel == 3'd0);
    assign at_bind  = (reg_num == 5'd2)  && (reg_sel == 3'd2);

    // Random reads 63 in the first cycle after reset (R1)
    assert_rand_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && at_rand) |-> (rd_data == 32'd63));

    // Each binding carries its own thread id after reset (R1)
    assert_bind_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && at_bind) |-> (rd_data[28:21] == 8'(tid)));

    // Software write to cause merges through its mask (R2)
    assert_cause_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && !wr_raw && at_cause) |=>
        (at_cause -> (rd_data == (($past(wr_data) & CAUSE_M) |
                                  ($past(rd_data) & ~CAUSE_M)))));

    // Software write to the id register changes nothing (R3)
    assert_id_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && !wr_raw && at_id) |=>
        (at_id -> (rd_data == $past(rd_data))));

    // Raw write to cause stores the whole word (R4)
    assert_raw_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en && wr_raw && at_cause) |=>
        (at_cause -> (rd_data == $past(wr_data))));

    // No register lives at select 7 (R8)
    assert_sel7_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == 3'd7) |-> (rd_data == 32'd0));

endmodule

bind crf_top crf_top_checker #(.TID_W(TID_W)) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .tid     (tid),
    .reg_num (reg_num),
    .reg_sel (reg_sel),
    .wr_en   (wr_en),
    .wr_raw  (wr_raw),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/crf_top_bench.sv
// Bench for crf_top: a behavioural reference model in an associative array
// keyed by slot index and copy, compared with rd_data on every clock.
module crf_top_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          NUM_TC     = 4;
    localparam int          NUM_VP     = 2;
    localparam logic [31:0] CORE_ID    = 32'h0001_9300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  tid = '0;
    logic [4:0]  reg_num = '0;
    logic [2:0]  reg_sel = '0;
    logic        wr_en = 1'b0;
    logic        wr_raw = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] mdl [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    crf_top #(.NUM_TC(NUM_TC), .NUM_VP(NUM_VP), .CORE_ID_RESET(CORE_ID)) u_crf_top (
        .clk (clk), .rst_n (rst_n), .tid (tid), .reg_num (reg_num),
        .reg_sel (reg_sel), .wr_en (wr_en), .wr_raw (wr_raw),
        .wr_data (wr_data), .rd_data (rd_data)
    );

    // 0 none, 1 shared, 2 per virtual processor, 3 per thread
    function automatic int kind_of(input int idx);
        case (idx)
            0, 8, 16, 24, 32, 40, 41, 64, 97, 98, 104, 120, 128, 129, 131: return 1;
            9, 10, 49, 121: return 2;
            17, 18, 20, 96, 136, 184: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic logic [31:0] mask_of(input int idx);
        case (idx)
            0:   return 32'h7FFF_FFFF;
            16, 24: return 32'h3FFF_FFFF;
            32:  return 32'hFF80_0000;
            40:  return 32'h1FFF_F800;
            41:  return 32'h1000_0000;
            97:  return 32'h0000_03E0;
            98:  return 32'h0000_F3C0;
            104: return 32'h08C0_0300;
            121: return 32'h3FFF_F000;
            128: return 32'h7FFF_0007;
            96:  return 32'hFF78_FF17;
            8, 64, 120, 129, 131, 136: return 32'h0;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] get(input int key);
        return mdl.exists(key) ? mdl[key] : 32'h0;
    endfunction

    function automatic bit key_of(input int idx, input int t, output int key);
        int k = kind_of(idx);
        int vp;
        key = 0;
        if (k == 0) return 0;
        if (k == 1) begin key = idx * 16; return 1; end
        if (t >= NUM_TC) return 0;
        if (k == 3) begin key = idx * 16 + t; return 1; end
        vp = int'(get(18 * 16 + t) & 32'hF);
        if (vp >= NUM_VP) return 0;
        key = idx * 16 + vp;
        return 1;
    endfunction

    function automatic logic [31:0] model_read(input int idx, input int t);
        int key;
        if (!key_of(idx, t, key)) return 32'h0;
        return get(key);
    endfunction

    task automatic model_write(input int idx, input int t, input bit raw,
                               input logic [31:0] d);
        int key;
        logic [31:0] m;
        if (key_of(idx, t, key)) begin
            m = raw ? 32'hFFFF_FFFF : mask_of(idx);
            mdl[key] = (d & m) | (get(key) & ~m);
        end
    endtask

    task automatic model_reset();
        mdl.delete();
        mdl[8 * 16]   = 32'd63;
        mdl[120 * 16] = CORE_ID;
        mdl[128 * 16] = 32'h8000_0000;
        for (int v = 0; v < NUM_VP; v++) mdl[121 * 16 + v] = 32'h8000_0000;
        for (int t = 0; t < NUM_TC; t++) begin
            mdl[18 * 16 + t] = 32'(t) << 21;
            mdl[96 * 16 + t] = 32'h0040_0004;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s num=%0d sel=%0d tid=%0d actual=%h expected=%h",
                     tag, reg_num, reg_sel, tid, act, exp);
        end
    endtask

    // One clock: drive, compare the combinational read, then commit to model
    task automatic op(input int n, input int s, input int t, input bit we,
                      input bit raw, input logic [31:0] d, input string tag);
        @(negedge clk);
        reg_num = 5'(n); reg_sel = 3'(s); tid = 2'(t);
        wr_en = we; wr_raw = raw; wr_data = d;
        #1;
        check(tag, rd_data, model_read(n * 8 + s, t));
        @(posedge clk);
        if (we) model_write(n * 8 + s, t, raw, d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int core_list [15] = '{0, 8, 16, 24, 32, 40, 41, 64, 97, 98, 104, 120, 128, 129, 131};
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 and R8: reset image of every slot and every thread
        for (int n = 0; n < 32; n++)
            for (int s = 0; s < 8; s++)
                for (int t = 0; t < NUM_TC; t++)
                    op(n, s, t, 1'b0, 1'b0, 32'h0, (kind_of(n*8+s) == 0) ? "R8" : "R1");

        // R2 and R3: all-ones then all-zeros through each shared mask
        foreach (core_list[i]) begin
            string tg = (mask_of(core_list[i]) == 0) ? "R3" : "R2";
            op(core_list[i] / 8, core_list[i] % 8, 0, 1'b1, 1'b0, 32'hFFFF_FFFF, tg);
            op(core_list[i] / 8, core_list[i] % 8, 1, 1'b0, 1'b0, 32'h0, tg);
            op(core_list[i] / 8, core_list[i] % 8, 0, 1'b1, 1'b0, 32'h0, tg);
            op(core_list[i] / 8, core_list[i] % 8, 0, 1'b0, 1'b0, 32'h0, tg);
        end

        // R5: per-thread status and halt copies stay separate
        for (int t = 0; t < NUM_TC; t++) begin
            op(12, 0, t, 1'b1, 1'b0, 32'hA5A5_5A5A ^ 32'(t * 32'h0101_0101), "R5");
            op(2, 4, t, 1'b1, 1'b0, 32'(t + 7), "R5");
        end
        for (int t = 0; t < NUM_TC; t++) begin
            op(12, 0, t, 1'b0, 1'b0, 32'h0, "R5");
            op(2, 4, t, 1'b0, 1'b0, 32'h0, "R5");
        end

        // R6: bank picked through the binding field
        op(2, 2, 1, 1'b1, 1'b0, 32'h0020_0001, "R6");
        op(15, 1, 0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R6");
        op(15, 1, 1, 1'b1, 1'b0, 32'h1234_5678, "R6");
        op(1, 1, 1, 1'b1, 1'b0, 32'hCAFE_0001, "R6");
        for (int t = 0; t < NUM_TC; t++) begin
            op(15, 1, t, 1'b0, 1'b0, 32'h0, "R6");
            op(1, 1, t, 1'b0, 1'b0, 32'h0, "R6");
        end
        op(2, 2, 1, 1'b1, 1'b0, 32'h0020_0000, "R6");
        op(1, 1, 1, 1'b0, 1'b0, 32'h0, "R6");

        // R9: out-of-range binding reads zero and drops writes
        op(2, 2, 2, 1'b1, 1'b0, 32'h0000_0005, "R9");
        op(15, 1, 2, 1'b1, 1'b0, 32'h5555_5555, "R9");
        op(15, 1, 2, 1'b0, 1'b0, 32'h0, "R9");
        op(15, 1, 0, 1'b0, 1'b0, 32'h0, "R9");
        op(1, 2, 3, 1'b0, 1'b0, 32'h0, "R9");

        // R4: raw writes bypass the mask, including read-only slots
        op(15, 0, 0, 1'b1, 1'b1, 32'hDEAD_BEEF, "R4");
        op(1, 0, 0, 1'b1, 1'b1, 32'h0000_0011, "R4");
        op(17, 0, 3, 1'b1, 1'b1, 32'h0BAD_F00D, "R4");
        op(12, 0, 0, 1'b1, 1'b1, 32'hFFFF_FFFF, "R4");
        op(13, 0, 2, 1'b1, 1'b1, 32'h1357_9BDF, "R4");
        op(15, 0, 1, 1'b0, 1'b0, 32'h0, "R4");
        op(1, 0, 2, 1'b0, 1'b0, 32'h0, "R4");
        op(17, 0, 3, 1'b0, 1'b0, 32'h0, "R4");
        op(17, 0, 0, 1'b0, 1'b0, 32'h0, "R4");
        op(12, 0, 0, 1'b0, 1'b0, 32'h0, "R4");
        op(13, 0, 0, 1'b0, 1'b0, 32'h0, "R4");

        // R7: shared register seen alike by every thread
        op(0, 0, 2, 1'b1, 1'b0, 32'h0000_1234, "R7");
        for (int t = 0; t < NUM_TC; t++) op(0, 0, t, 1'b0, 1'b0, 32'h0, "R7");

        // R8: writes to unimplemented slots touch nothing
        op(16, 2, 0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R8");
        op(0, 5, 1, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8");
        op(31, 7, 2, 1'b1, 1'b0, 32'hFFFF_FFFF, "R8");
        op(2, 3, 3, 1'b1, 1'b1, 32'hFFFF_FFFF, "R8");
        op(16, 2, 0, 1'b0, 1'b0, 32'h0, "R8");
        op(0, 5, 1, 1'b0, 1'b0, 32'h0, "R8");
        op(2, 3, 3, 1'b0, 1'b0, 32'h0, "R8");
        op(0, 0, 0, 1'b0, 1'b0, 32'h0, "R8");
        op(16, 0, 0, 1'b0, 1'b0, 32'h0, "R8");

        // R10: old value during the write cycle, new value after the edge
        op(4, 0, 0, 1'b1, 1'b0, 32'hFFFF_FFFF, "R10");
        op(4, 0, 0, 1'b1, 1'b0, 32'h0080_0000, "R10");
        op(4, 0, 0, 1'b0, 1'b0, 32'h0, "R10");

        // R1: a second reset restores the image
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < NUM_TC; t++) begin
            op(2, 2, t, 1'b0, 1'b0, 32'h0, "R1");
            op(12, 0, t, 1'b0, 1'b0, 32'h0, "R1");
            op(15, 1, t, 1'b0, 1'b0, 32'h0, "R1");
        end
        op(15, 0, 0, 1'b0, 1'b0, 32'h0, "R1");
        op(1, 0, 0, 1'b0, 1'b0, 32'h0, "R1");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule